// File: doc/BRIEF.md
# Transmit/Receive Pin Switcher

This block drives several 16-bit banks of general-purpose pins that lead to plug-in daughterboards. Each pin has an output-enable bit and a value bit. A software register normally sets the value. For pins marked in a per-bank selection mask, the value instead follows a transmit pattern or a receive pattern. The choice between the two depends on an internal transmit flag, which is derived from a "transmit FIFO holds data" input.

The transmit flag does not follow the FIFO input at once. Its assertion waits for a programmable number of clock ticks, and its release waits for a separately programmable number. If the FIFO input changes back before the count runs out, the count starts over. Software writes every setting through a single-cycle write port with a 7-bit address and 32-bit data. A global bit turns pattern switching on. A per-bank debug bit hands that bank's pin values to an internal debug bus.

Top module: `trx_pin_switch`

## Requirements
- R1: After reset every output-enable bit, every pin value and the transmit flag are 0.
- R2: Writing address 5+b changes the output-enable register of bank b. Data bits 31:16 are a write mask and bits 15:0 are the value, so only bits whose mask bit is 1 take the new value. Writes to other addresses leave output enables unchanged.
- R3: Writing address 9+b changes the normal output register of bank b, with the same bit-mask rule as R2. When switching is off and debug is off, the bank's pins show this register.
- R4: With switching on, a pin whose selection-mask bit is 1 shows its transmit-pattern bit while the transmit flag is 1, and its receive-pattern bit otherwise. A pin whose mask bit is 0 shows its normal output bit.
- R5: Bank b's selection mask, transmit pattern and receive pattern sit at addresses 20+3b, 21+3b and 22+3b. These registers take only data bits 15:0.
- R6: The rise delay sits at address 2 and takes data bits 15:0. After the FIFO input goes to 1 and stays there, the transmit flag rises on the clock edge that follows D further edges. With D=0 it rises on the next edge.
- R7: The fall delay sits at address 3 and applies in the same way when the FIFO input returns to 0.
- R8: A FIFO pulse shorter than the rise delay never raises the transmit flag. The count restarts from zero on the next pulse.
- R9: Bit b of address 14 gives bank b's pin values to the matching 16-bit slice of the debug bus. Other banks are not affected.
- R10: Bit 0 of address 13 enables switching. While it is 0, every non-debug pin follows its normal output register, even when mask bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register address |
| wr_data | input | 32 | Register write data |
| fifo_has_data | input | 1 | Transmit FIFO is not empty |
| dbg_bus | input | NUM_BANKS*16 | Debug values, 16 bits per bank |
| pin_oe | output | NUM_BANKS*16 | Per-pin output enable (1 = drive toward board) |
| pin_out | output | NUM_BANKS*16 | Per-pin output value |
| tx_state | output | 1 | Delayed transmit flag |

## Verification
The bench builds the block with its defaults: four banks and a 16-bit delay counter. With these values the whole address map, from the delay registers up to the last bank's receive pattern at address 31, is reachable. Small delay values of 0, 1 and 3 fit in the counter, which brings into reach the zero-delay case, asymmetric rise and fall, and a pulse cut off and restarted inside the count window. Pattern checks compare the full 64-bit pin and enable vectors, so a stray update in a neighbouring bank shows up.

// File: rtl/trx_pin_pkg.sv
package trx_pin_pkg;
  localparam int unsigned ADDR_W  = 7;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BANK_W  = 16;
  localparam int unsigned MASK_LSB = 16;

  localparam int unsigned ADR_RISE_DLY = 2;
  localparam int unsigned ADR_FALL_DLY = 3;
  localparam int unsigned ADR_OE_BASE  = 5;
  localparam int unsigned ADR_IO_BASE  = 9;
  localparam int unsigned ADR_SW_CTL   = 13;
  localparam int unsigned ADR_DBG_CTL  = 14;
  localparam int unsigned ADR_PAT_BASE = 20;
  localparam int unsigned PAT_STRIDE   = 3;
endpackage

// File: rtl/trx_rst_sync.sv
module trx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/trx_reg_file.sv
module trx_reg_file
  import trx_pin_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned DLY_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [NUM_BANKS*BANK_W-1:0] oe_vec,
  output logic [NUM_BANKS*BANK_W-1:0] io_vec,
  output logic [NUM_BANKS*BANK_W-1:0] msk_vec,
  output logic [NUM_BANKS*BANK_W-1:0] txv_vec,
  output logic [NUM_BANKS*BANK_W-1:0] rxv_vec,
  output logic [DLY_W-1:0]            rise_dly,
  output logic [DLY_W-1:0]            fall_dly,
  output logic                        sw_en,
  output logic [NUM_BANKS-1:0]        dbg_en
);
  logic [BANK_W-1:0] wmask;
  logic [BANK_W-1:0] wval;

  assign wmask = wr_data[MASK_LSB +: BANK_W];
  assign wval  = wr_data[BANK_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] A_OE  = ADDR_W'(ADR_OE_BASE + b);
    localparam logic [ADDR_W-1:0] A_IO  = ADDR_W'(ADR_IO_BASE + b);
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(ADR_PAT_BASE + PAT_STRIDE * b);
    localparam logic [ADDR_W-1:0] A_TXV = ADDR_W'(ADR_PAT_BASE + PAT_STRIDE * b + 1);
    localparam logic [ADDR_W-1:0] A_RXV = ADDR_W'(ADR_PAT_BASE + PAT_STRIDE * b + 2);

    logic              oe_ld, io_ld, msk_ld, txv_ld, rxv_ld;
    logic [BANK_W-1:0] oe_q, oe_d, io_q, io_d, msk_q, txv_q, rxv_q;

    always_comb begin
      oe_ld  = wr_en && (wr_addr == A_OE);
      io_ld  = wr_en && (wr_addr == A_IO);
      msk_ld = wr_en && (wr_addr == A_MSK);
      txv_ld = wr_en && (wr_addr == A_TXV);
      rxv_ld = wr_en && (wr_addr == A_RXV);
      oe_d   = (oe_q & ~wmask) | (wval & wmask);
      io_d   = (io_q & ~wmask) | (wval & wmask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        oe_q  <= '0;
        io_q  <= '0;
        msk_q <= '0;
        txv_q <= '0;
        rxv_q <= '0;
      end else begin
        if (oe_ld)  oe_q  <= oe_d;
        if (io_ld)  io_q  <= io_d;
        if (msk_ld) msk_q <= wval;
        if (txv_ld) txv_q <= wval;
        if (rxv_ld) rxv_q <= wval;
      end
    end

    assign oe_vec [b*BANK_W +: BANK_W] = oe_q;
    assign io_vec [b*BANK_W +: BANK_W] = io_q;
    assign msk_vec[b*BANK_W +: BANK_W] = msk_q;
    assign txv_vec[b*BANK_W +: BANK_W] = txv_q;
    assign rxv_vec[b*BANK_W +: BANK_W] = rxv_q;
  end

  logic rise_ld, fall_ld, swc_ld, dbg_ld;

  always_comb begin
    rise_ld = wr_en && (wr_addr == ADDR_W'(ADR_RISE_DLY));
    fall_ld = wr_en && (wr_addr == ADDR_W'(ADR_FALL_DLY));
    swc_ld  = wr_en && (wr_addr == ADDR_W'(ADR_SW_CTL));
    dbg_ld  = wr_en && (wr_addr == ADDR_W'(ADR_DBG_CTL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_dly <= '0;
      fall_dly <= '0;
      sw_en    <= 1'b0;
      dbg_en   <= '0;
    end else begin
      if (rise_ld) rise_dly <= wr_data[DLY_W-1:0];
      if (fall_ld) fall_dly <= wr_data[DLY_W-1:0];
      if (swc_ld)  sw_en    <= wr_data[0];
      if (dbg_ld)  dbg_en   <= wr_data[NUM_BANKS-1:0];
    end
  end
endmodule

// File: rtl/trx_tr_delay.sv
module trx_tr_delay #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_tx,
  input  logic [DLY_W-1:0] rise_dly,
  input  logic [DLY_W-1:0] fall_dly,
  output logic             tx_state
);
  logic             st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic [DLY_W-1:0] limit;
  logic             pending;

  always_comb begin
    pending = raw_tx ^ st_q;
    limit   = st_q ? fall_dly : rise_dly;
    st_d    = st_q;
    cnt_d   = '0;
    if (pending) begin
      if (cnt_q >= limit) st_d  = raw_tx;
      else                cnt_d = cnt_q + DLY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign tx_state = st_q;
endmodule

// File: rtl/trx_bank_mux.sv
module trx_bank_mux #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] io_val,
  input  logic [W-1:0] sel_mask,
  input  logic [W-1:0] tx_pat,
  input  logic [W-1:0] rx_pat,
  input  logic [W-1:0] dbg_val,
  input  logic         sw_en,
  input  logic         dbg_sel,
  input  logic         tx_state,
  output logic [W-1:0] pin_val
);
  logic [W-1:0] pattern;
  logic [W-1:0] switched;

  always_comb begin
    pattern  = tx_state ? tx_pat : rx_pat;
    switched = (sel_mask & pattern) | (~sel_mask & io_val);
    if (dbg_sel)    pin_val = dbg_val;
    else if (sw_en) pin_val = switched;
    else            pin_val = io_val;
  end
endmodule

// File: rtl/trx_pin_switch.sv
module trx_pin_switch
  import trx_pin_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned DLY_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [6:0]                  wr_addr,
  input  logic [31:0]                 wr_data,
  input  logic                        fifo_has_data,
  input  logic [NUM_BANKS*16-1:0]     dbg_bus,
  output logic [NUM_BANKS*16-1:0]     pin_oe,
  output logic [NUM_BANKS*16-1:0]     pin_out,
  output logic                        tx_state
);
  localparam int unsigned PW = NUM_BANKS * BANK_W;

  logic          rst_sync_n;
  logic [PW-1:0] io_vec, msk_vec, txv_vec, rxv_vec;
  logic [DLY_W-1:0] rise_dly, fall_dly;
  logic          sw_en;
  logic [NUM_BANKS-1:0] dbg_en;

  trx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  trx_reg_file #(.NUM_BANKS(NUM_BANKS), .DLY_W(DLY_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .oe_vec   (pin_oe),
    .io_vec   (io_vec),
    .msk_vec  (msk_vec),
    .txv_vec  (txv_vec),
    .rxv_vec  (rxv_vec),
    .rise_dly (rise_dly),
    .fall_dly (fall_dly),
    .sw_en    (sw_en),
    .dbg_en   (dbg_en)
  );

  trx_tr_delay #(.DLY_W(DLY_W)) u_delay (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .raw_tx   (fifo_has_data),
    .rise_dly (rise_dly),
    .fall_dly (fall_dly),
    .tx_state (tx_state)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mux
    trx_bank_mux #(.W(BANK_W)) u_mux (
      .io_val   (io_vec [b*BANK_W +: BANK_W]),
      .sel_mask (msk_vec[b*BANK_W +: BANK_W]),
      .tx_pat   (txv_vec[b*BANK_W +: BANK_W]),
      .rx_pat   (rxv_vec[b*BANK_W +: BANK_W]),
      .dbg_val  (dbg_bus[b*BANK_W +: BANK_W]),
      .sw_en    (sw_en),
      .dbg_sel  (dbg_en[b]),
      .tx_state (tx_state),
      .pin_val  (pin_out[b*BANK_W +: BANK_W])
    );
  end
endmodule

// File: rtl/trx_pin_switch_chk.sv
module trx_pin_switch_chk #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned DLY_W     = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rst_sync_n,
  input logic                    wr_en,
  input logic [6:0]              wr_addr,
  input logic [31:0]             wr_data,
  input logic                    fifo_has_data,
  input logic [NUM_BANKS*16-1:0] pin_oe,
  input logic                    tx_state,
  input logic [DLY_W-1:0]        rise_dly
);
  localparam logic [6:0] OE_LO = 7'd5;
  localparam logic [6:0] OE_HI = 7'(5 + NUM_BANKS);

  AST_RISE_NEEDS_FIFO: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    $rose(tx_state) |-> $past(fifo_has_data)); // R6

  AST_FALL_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    $fell(tx_state) |-> !$past(fifo_has_data)); // R7

  AST_ZERO_RISE_NEXT: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (rise_dly == '0 && !tx_state && fifo_has_data) |=> tx_state); // R6

  AST_OE_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (!wr_en || wr_addr < OE_LO || wr_addr >= OE_HI) |=> $stable(pin_oe)); // R2

  AST_OE_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (wr_en && wr_data[31:16] == 16'h0) |=> $stable(pin_oe)); // R2
endmodule

bind trx_pin_switch trx_pin_switch_chk #(.NUM_BANKS(NUM_BANKS), .DLY_W(DLY_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rst_sync_n    (rst_sync_n),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .fifo_has_data (fifo_has_data),
  .pin_oe        (pin_oe),
  .tx_state      (tx_state),
  .rise_dly      (rise_dly)
);

// File: tb/trx_pin_switch_tb.sv
module trx_pin_switch_tb;
  localparam int NB = 4;
  localparam int PW = NB * 16;
  localparam logic [PW-1:0] DBG_PAT = 64'h1234_5678_9ABC_DEF0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [6:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          fifo_has_data = 1'b0;
  logic [PW-1:0] dbg_bus = DBG_PAT;
  logic [PW-1:0] pin_oe, pin_out;
  logic          tx_state;

  always #10 clk = ~clk;

  trx_pin_switch u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fifo_has_data(fifo_has_data), .dbg_bus(dbg_bus),
    .pin_oe(pin_oe), .pin_out(pin_out), .tx_state(tx_state)
  );

  typedef struct {
    string         tag;
    logic [PW-1:0] out;
    logic [PW-1:0] oe;
    logic          tx;
  } exp_t;
  exp_t sb[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_oe [NB];
  logic [15:0] m_io [NB];
  logic [15:0] m_msk[NB];
  logic [15:0] m_txv[NB];
  logic [15:0] m_rxv[NB];
  logic        m_sw;
  logic [NB-1:0] m_dbg;
  logic        m_tx;

  function automatic logic [PW-1:0] model_out();
    logic [PW-1:0] v;
    for (int b = 0; b < NB; b++) begin
      logic [15:0] pat;
      pat = m_tx ? m_txv[b] : m_rxv[b];
      if (m_dbg[b])  v[b*16 +: 16] = DBG_PAT[b*16 +: 16];
      else if (m_sw) v[b*16 +: 16] = (m_msk[b] & pat) | (~m_msk[b] & m_io[b]);
      else           v[b*16 +: 16] = m_io[b];
    end
    return v;
  endfunction

  function automatic logic [PW-1:0] model_oe();
    logic [PW-1:0] v;
    for (int b = 0; b < NB; b++) v[b*16 +: 16] = m_oe[b];
    return v;
  endfunction

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic write_reg(input logic [6:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (a >= 5 && a < 5 + NB)
      m_oe[a-5] = (m_oe[a-5] & ~d[31:16]) | (d[15:0] & d[31:16]);
    else if (a >= 9 && a < 9 + NB)
      m_io[a-9] = (m_io[a-9] & ~d[31:16]) | (d[15:0] & d[31:16]);
    else if (a == 13) m_sw = d[0];
    else if (a == 14) m_dbg = d[NB-1:0];
    else if (a >= 20 && a < 20 + 3*NB) begin
      case ((a - 20) % 3)
        0: m_msk[(a-20)/3] = d[15:0];
        1: m_txv[(a-20)/3] = d[15:0];
        default: m_rxv[(a-20)/3] = d[15:0];
      endcase
    end
  endtask

  task automatic check(input string tag);
    exp_t e;
    e.tag = tag; e.out = model_out(); e.oe = model_oe(); e.tx = m_tx;
    sb.push_back(e);
    @(negedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (pin_out !== e.out || pin_oe !== e.oe || tx_state !== e.tx) begin
        errors++;
        $display("FAIL %s: out=%h oe=%h tx=%b expected out=%h oe=%h tx=%b",
                 e.tag, pin_out, pin_oe, tx_state, e.out, e.oe, e.tx);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_oe[b] = '0; m_io[b] = '0; m_msk[b] = '0; m_txv[b] = '0; m_rxv[b] = '0;
    end
    m_sw = 0; m_dbg = '0; m_tx = 0;
    tick(3);
    check("R1 reset state");
    @(negedge clk); rst_n = 1'b1;
    tick(4);
    check("R1 after reset release");

    // R2: masked output-enable writes
    write_reg(7'd5, 32'hFFFF_A5A5);
    check("R2 full-mask enable write");
    write_reg(7'd5, 32'h00F0_FFFF);
    check("R2 partial-mask enable write");
    write_reg(7'd8, 32'h0000_FFFF);
    check("R2 empty mask leaves enables");

    // R3: masked normal output writes
    write_reg(7'd10, 32'hFFFF_1234);
    write_reg(7'd11, 32'h0F0F_FFFF);
    check("R3 normal output registers");

    // R5 / R10: pattern registers load, switching still off
    write_reg(7'd20, 32'hFFFF_00FF);
    write_reg(7'd21, 32'h0000_AAAA);
    write_reg(7'd22, 32'hFFFF_5555);
    write_reg(7'd9,  32'hFFFF_F000);
    check("R10 switching off ignores mask");

    // R4: switching on, receive pattern
    write_reg(7'd13, 32'h0000_0001);
    check("R4 receive pattern on masked pins");

    // R6: rise delay 3
    write_reg(7'd2, 32'hFFFF_0003);
    fifo_has_data = 1'b1;
    tick(3);
    check("R6 flag still low inside rise delay");
    tick(1);
    m_tx = 1;
    check("R6 flag high after rise delay, R4 transmit pattern");

    // R7: fall delay 1
    write_reg(7'd3, 32'h0000_0001);
    fifo_has_data = 1'b0;
    tick(1);
    check("R7 flag still high inside fall delay");
    tick(1);
    m_tx = 0;
    check("R7 flag low after fall delay");

    // R8: short pulse, then restart
    fifo_has_data = 1'b1;
    tick(2);
    fifo_has_data = 1'b0;
    tick(1);
    check("R8 short pulse ignored");
    fifo_has_data = 1'b1;
    tick(3);
    check("R8 count restarted");
    tick(1);
    m_tx = 1;
    check("R8 flag high after full count");
    fifo_has_data = 1'b0;
    tick(2);
    m_tx = 0;
    check("R7 flag released");

    // R6: zero rise delay
    write_reg(7'd2, 32'h0000_0000);
    fifo_has_data = 1'b1;
    tick(1);
    m_tx = 1;
    check("R6 zero delay next edge");
    fifo_has_data = 1'b0;
    tick(2);
    m_tx = 0;
    check("R7 release after zero-delay rise");

    // R9: debug override of bank 1
    write_reg(7'd14, 32'h0000_0002);
    check("R9 debug bank 1 only");
    write_reg(7'd14, 32'h0000_0000);
    check("R9 debug released");

    // R5: last bank layout
    write_reg(7'd29, 32'h0000_F0F0);
    write_reg(7'd30, 32'h0000_FFFF);
    write_reg(7'd31, 32'hFFFF_0C0C);
    check("R5 last bank receive pattern");
    fifo_has_data = 1'b1;
    tick(1);
    m_tx = 1;
    check("R5 last bank transmit pattern");

    tick(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule